// File: doc/BRIEF.md
# Linked-List Multi-Block DMA Channel

This block is a single DMA channel that works through a chain of blocks. Each block is described by a four-word list item held in memory. Software sets the global enable and writes the first destination address, the interrupt masks and a pointer to the first list item. It then starts the channel. For each item the channel reads all four words over a one-request-at-a-time memory master port. It loads its source address, control word and next-item pointer from the item, then moves the block one word per beat: a read from the source followed by a write to the destination. When the block is finished it writes the control word back to the item with a completion flag set.

The destination word inside each item is read but never used. The destination address register therefore keeps counting from block to block, and the blocks of the chain land next to each other. A next-item pointer of zero marks the last block. After that block the channel drops back to idle and reports transfer completion. An error response on any access stops the channel at once.

The engine is one state machine. Its states are:
- IDLE, the rest state.
- FETCH_REQ and FETCH_RSP, which issue and collect the four item words.
- RD_REQ and RD_RSP, which read one source word.
- WR_REQ and WR_RSP, which write that word to the destination.
- WB_REQ and WB_RSP, which write back the control word.

Its transitions are:
- IDLE to FETCH_REQ on start.
- Each *_REQ to the matching *_RSP when the request is accepted.
- FETCH_RSP back to FETCH_REQ while words of the item remain. After the fourth word it goes to RD_REQ, or to WB_REQ when the length is zero.
- RD_RSP to WR_REQ.
- WR_RSP to RD_REQ while beats remain, else to WB_REQ.
- WB_RSP to FETCH_REQ when the next pointer is non-zero, else to IDLE.
- Any *_RSP to IDLE on an error response.

Top module: `lldma_channel`

## Requirements
- R1: After reset the channel is idle. No memory request is issued, both interrupts are low, and the channel-enable, raw-status and masked-status registers read 0.
- R2: A chain starts only when bit 0 of the global-enable register (index 0) is 1 and a write with bit 0 = 1 reaches the channel-enable register (index 1). Any other write to index 1 issues no memory request. While a chain runs, index 1 reads 1.
- R3: A list item at byte address P is read as four words, in order, from P, P+4, P+8 and P+12. These words are the source address, the destination address, the next-item pointer and the control word. The first item comes from the pointer register (index 3).
- R4: The destination word of each item is discarded. The destination address continues from where the previous block ended, and the destination register (index 2) reads the final running address.
- R5: Each beat reads the source address, then writes the word read to the destination address, with at most one request outstanding. A request is held stable until it is accepted. The control word holds the source address mode in bits [9:8] and the destination address mode in bits [11:10]. Mode 0 adds 4 after each beat, mode 1 subtracts 4, and modes 2 and 3 hold the address.
- R6: Control bits [7:0] give the block length in words. A length of 0 moves no data, but the item is still written back.
- R7: At the end of each block the control word, with bit 31 set and all other bits unchanged, is written to P+12. Raw status bit 1 (block done) is then set, and the next item is fetched at once without waiting for that bit to be cleared.
- R8: When the next-item pointer loaded for the finished block is 0, the channel returns to idle, index 1 reads 0, and raw status bit 0 (transfer done) is set.
- R9: An error response to any access ends the chain at once. The channel issues no further request, sets raw status bit 2 (error) and reads 0 at index 1.
- R10: Writing to the clear register (index 9) clears each raw status bit that has a 1 in the written word, and leaves the other bits as they were. Raw status (index 7) and masked status (index 8) then read 0 in the cleared bits.
- R11: Masked status equals raw status AND the mask register (index 4, bits [2:0]). The transfer-done interrupt output follows masked bit 0, and the block-done interrupt output follows masked bit 1.
- R12: Writes to the destination (index 2) and pointer (index 3) registers while a chain is running have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| m_req_valid | output | 1 | Memory request valid |
| m_req_ready | input | 1 | Memory request accepted |
| m_req_we | output | 1 | Memory request is a write |
| m_req_addr | output | 32 | Memory byte address |
| m_req_wdata | output | 32 | Memory write data |
| m_rsp_valid | input | 1 | Memory response valid |
| m_rsp_data | input | 32 | Memory read data |
| m_rsp_err | input | 1 | Memory response carries an error |
| irq_blk | output | 1 | Block-done interrupt |
| irq_tfr | output | 1 | Transfer-done interrupt |

## Verification
The bench builds the full expected sequence of memory requests for every combination of source and destination address mode. It then compares the sequence request by request, with the memory stalling its ready signal.

Several corner cases are targeted directly:
- A channel that reloaded the destination from the item would write to the decoy address planted in each item.
- A channel that mishandled a zero-length block would issue a stray beat or skip the write-back.
- A channel that waited on the block interrupt would stall in the middle of the chain.
- Error responses are injected on an item fetch and on a source read. A channel that kept going after an error would show extra requests.
- Register writes made during a run would change the addresses if they were not ignored.
- Partial clears and partial masks would expose status bits that are tied together wrongly.

// File: rtl/lldma_pkg.sv
`timescale 1ns/1ps
package lldma_pkg;

    // Engine states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_RSP,
        ST_RD_REQ,
        ST_RD_RSP,
        ST_WR_REQ,
        ST_WR_RSP,
        ST_WB_REQ,
        ST_WB_RSP
    } state_t;

    // Register word indices
    localparam logic [3:0] RI_GCFG = 4'd0;
    localparam logic [3:0] RI_CHEN = 4'd1;
    localparam logic [3:0] RI_DST  = 4'd2;
    localparam logic [3:0] RI_NXT  = 4'd3;
    localparam logic [3:0] RI_MASK = 4'd4;
    localparam logic [3:0] RI_SRC  = 4'd5;
    localparam logic [3:0] RI_CTL  = 4'd6;
    localparam logic [3:0] RI_RAW  = 4'd7;
    localparam logic [3:0] RI_STAT = 4'd8;
    localparam logic [3:0] RI_CLR  = 4'd9;

    // Status bit positions
    localparam int SB_TFR = 0;
    localparam int SB_BLK = 1;
    localparam int SB_ERR = 2;
    localparam int SB_N   = 3;

    // Address modes
    localparam logic [1:0] AM_INC = 2'd0;
    localparam logic [1:0] AM_DEC = 2'd1;

endpackage

// File: rtl/lldma_step.sv
`timescale 1ns/1ps
module lldma_step
    import lldma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int STEP  = 4
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    mode_i,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    always_comb begin
        unique case (mode_i)
            AM_INC:  addr_o = addr_i + STEP_V;
            AM_DEC:  addr_o = addr_i - STEP_V;
            default: addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/lldma_engine.sv
`timescale 1ns/1ps
module lldma_engine
    import lldma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LEN_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          sw_dst_we_i,
    input  logic          sw_nxt_we_i,
    input  logic [AW-1:0] sw_wdata_i,
    output logic          busy_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [AW-1:0] nxt_o,
    output logic [DW-1:0] ctl_o,
    output logic          blk_done_o,
    output logic          xfer_done_o,
    output logic          err_o,
    output logic          m_req_valid,
    input  logic          m_req_ready,
    output logic          m_req_we,
    output logic [AW-1:0] m_req_addr,
    output logic [DW-1:0] m_req_wdata,
    input  logic          m_rsp_valid,
    input  logic [DW-1:0] m_rsp_data,
    input  logic          m_rsp_err
);
    localparam int              WSTEP     = DW / 8;
    localparam int              SM_LSB    = LEN_W;
    localparam int              DM_LSB    = LEN_W + 2;
    localparam int              DONE_BIT  = DW - 1;
    localparam int              ITEM_WRDS = 4;
    localparam int              IDX_W     = $clog2(ITEM_WRDS);
    localparam logic [IDX_W-1:0] IDX_SRC  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_NXT  = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_CTL  = IDX_W'(ITEM_WRDS - 1);
    localparam logic [AW-1:0]   CTL_OFS   = AW'((ITEM_WRDS - 1) * WSTEP);
    localparam logic [DW-1:0]   DONE_MASK = DW'(1) << DONE_BIT;
    localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

    state_t            state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  remain_q;
    logic [AW-1:0]     item_q, src_q, dst_q, nxt_q;
    logic [DW-1:0]     ctl_q, data_q;
    logic [AW-1:0]     src_next, dst_next;
    logic              rsp_ok, rsp_bad, in_rsp;

    assign rsp_ok  = m_rsp_valid && !m_rsp_err;
    assign rsp_bad = m_rsp_valid &&  m_rsp_err;
    assign in_rsp  = (state_q == ST_FETCH_RSP) || (state_q == ST_RD_RSP) ||
                     (state_q == ST_WR_RSP)    || (state_q == ST_WB_RSP);

    lldma_step #(.AW(AW), .STEP(WSTEP)) u_src_step (
        .addr_i (src_q),
        .mode_i (ctl_q[SM_LSB +: 2]),
        .addr_o (src_next)
    );

    lldma_step #(.AW(AW), .STEP(WSTEP)) u_dst_step (
        .addr_i (dst_q),
        .mode_i (ctl_q[DM_LSB +: 2]),
        .addr_o (dst_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_FETCH_REQ;
            ST_FETCH_REQ: if (m_req_ready) state_d = ST_FETCH_RSP;
            ST_FETCH_RSP: begin
                if (rsp_bad) state_d = ST_IDLE;
                else if (rsp_ok) begin
                    if (idx_q != IDX_CTL) state_d = ST_FETCH_REQ;
                    else if (m_rsp_data[LEN_W-1:0] == '0) state_d = ST_WB_REQ;
                    else state_d = ST_RD_REQ;
                end
            end
            ST_RD_REQ:    if (m_req_ready) state_d = ST_RD_RSP;
            ST_RD_RSP: begin
                if (rsp_bad) state_d = ST_IDLE;
                else if (rsp_ok) state_d = ST_WR_REQ;
            end
            ST_WR_REQ:    if (m_req_ready) state_d = ST_WR_RSP;
            ST_WR_RSP: begin
                if (rsp_bad) state_d = ST_IDLE;
                else if (rsp_ok) state_d = (remain_q == LEN_ONE) ? ST_WB_REQ : ST_RD_REQ;
            end
            ST_WB_REQ:    if (m_req_ready) state_d = ST_WB_RSP;
            ST_WB_RSP: begin
                if (rsp_bad) state_d = ST_IDLE;
                else if (rsp_ok) state_d = (nxt_q == '0) ? ST_IDLE : ST_FETCH_REQ;
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    // Channel working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            remain_q <= '0;
            item_q   <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            nxt_q    <= '0;
            ctl_q    <= '0;
            data_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sw_dst_we_i) dst_q <= sw_wdata_i;
                    if (sw_nxt_we_i) nxt_q <= sw_wdata_i;
                    if (start_i) begin
                        item_q <= nxt_q;
                        idx_q  <= '0;
                    end
                end
                ST_FETCH_RSP: begin
                    if (rsp_ok) begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (idx_q == IDX_SRC) src_q <= AW'(m_rsp_data);
                        if (idx_q == IDX_NXT) nxt_q <= AW'(m_rsp_data);
                        if (idx_q == IDX_CTL) begin
                            ctl_q    <= m_rsp_data;
                            remain_q <= m_rsp_data[LEN_W-1:0];
                        end
                    end
                end
                ST_RD_RSP: if (rsp_ok) data_q <= m_rsp_data;
                ST_WR_RSP: begin
                    if (rsp_ok) begin
                        src_q    <= src_next;
                        dst_q    <= dst_next;
                        remain_q <= remain_q - LEN_ONE;
                    end
                end
                ST_WB_RSP: begin
                    if (rsp_ok) begin
                        ctl_q  <= ctl_q | DONE_MASK;
                        item_q <= nxt_q;
                        idx_q  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        m_req_valid = 1'b0;
        m_req_we    = 1'b0;
        m_req_addr  = '0;
        m_req_wdata = '0;
        unique case (state_q)
            ST_FETCH_REQ: begin
                m_req_valid = 1'b1;
                m_req_addr  = item_q + (AW'(idx_q) * AW'(WSTEP));
            end
            ST_RD_REQ: begin
                m_req_valid = 1'b1;
                m_req_addr  = src_q;
            end
            ST_WR_REQ: begin
                m_req_valid = 1'b1;
                m_req_we    = 1'b1;
                m_req_addr  = dst_q;
                m_req_wdata = data_q;
            end
            ST_WB_REQ: begin
                m_req_valid = 1'b1;
                m_req_we    = 1'b1;
                m_req_addr  = item_q + CTL_OFS;
                m_req_wdata = ctl_q | DONE_MASK;
            end
            default: ;
        endcase
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign src_o       = src_q;
    assign dst_o       = dst_q;
    assign nxt_o       = nxt_q;
    assign ctl_o       = ctl_q;
    assign blk_done_o  = (state_q == ST_WB_RSP) && rsp_ok;
    assign xfer_done_o = blk_done_o && (nxt_q == '0);
    assign err_o       = in_rsp && rsp_bad;

    // R5: a pending request holds its address and direction until accepted
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_valid && !m_req_ready) |=> (m_req_valid && $stable(m_req_addr) && $stable(m_req_we)));

    // R4: absorbing an item word never moves the destination address
    a_r4_dst_kept_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_RSP) |=> $stable(dst_q));

    // R8: the last block returns the engine to idle
    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_o |=> (state_q == ST_IDLE));

    // R9: an error response stops the chain
    a_r9_stop_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!m_req_valid && (state_q == ST_IDLE)));

    // R2: the idle engine stays idle without a start
    a_r2_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !start_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/lldma_regs.sv
`timescale 1ns/1ps
module lldma_regs
    import lldma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int RIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              busy_i,
    input  logic [AW-1:0]     src_i,
    input  logic [AW-1:0]     dst_i,
    input  logic [AW-1:0]     nxt_i,
    input  logic [DW-1:0]     ctl_i,
    input  logic              blk_i,
    input  logic              xfer_i,
    input  logic              err_i,
    output logic              start_o,
    output logic              sw_dst_we_o,
    output logic              sw_nxt_we_o,
    output logic              irq_blk_o,
    output logic              irq_tfr_o
);
    logic            gcfg_q;
    logic [SB_N-1:0] mask_q, raw_q, set_bits, clr_bits, stat;

    function automatic logic hit(input logic [RIDX_W-1:0] a, input logic [3:0] ri);
        return reg_we && (a == RIDX_W'(ri));
    endfunction

    assign start_o     = hit(reg_addr, RI_CHEN) && reg_wdata[0] && gcfg_q && !busy_i;
    assign sw_dst_we_o = hit(reg_addr, RI_DST) && !busy_i;
    assign sw_nxt_we_o = hit(reg_addr, RI_NXT) && !busy_i;

    always_comb begin
        set_bits         = '0;
        set_bits[SB_TFR] = xfer_i;
        set_bits[SB_BLK] = blk_i;
        set_bits[SB_ERR] = err_i;
        clr_bits = hit(reg_addr, RI_CLR) ? reg_wdata[SB_N-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcfg_q <= 1'b0;
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (hit(reg_addr, RI_GCFG)) gcfg_q <= reg_wdata[0];
            if (hit(reg_addr, RI_MASK)) mask_q <= reg_wdata[SB_N-1:0];
            raw_q <= (raw_q & ~clr_bits) | set_bits;
        end
    end

    assign stat      = raw_q & mask_q;
    assign irq_tfr_o = stat[SB_TFR];
    assign irq_blk_o = stat[SB_BLK];

    always_comb begin
        unique case (reg_addr)
            RIDX_W'(RI_GCFG): reg_rdata = DW'(gcfg_q);
            RIDX_W'(RI_CHEN): reg_rdata = DW'(busy_i);
            RIDX_W'(RI_DST):  reg_rdata = DW'(dst_i);
            RIDX_W'(RI_NXT):  reg_rdata = DW'(nxt_i);
            RIDX_W'(RI_MASK): reg_rdata = DW'(mask_q);
            RIDX_W'(RI_SRC):  reg_rdata = DW'(src_i);
            RIDX_W'(RI_CTL):  reg_rdata = ctl_i;
            RIDX_W'(RI_RAW):  reg_rdata = DW'(raw_q);
            RIDX_W'(RI_STAT): reg_rdata = DW'(stat);
            default:          reg_rdata = '0;
        endcase
    end

    // R10: a clear with no simultaneous event leaves the block bit low
    a_r10_clear_blk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit(reg_addr, RI_CLR) && reg_wdata[SB_BLK] && !blk_i) |=> !raw_q[SB_BLK]);

    // R8: transfer completion is recorded in raw status
    a_r8_tfr_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> raw_q[SB_TFR]);

    // R2: no start is produced while global enable is off
    a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!gcfg_q && !busy_i) |=> !busy_i);

endmodule

// File: rtl/lldma_channel.sv
`timescale 1ns/1ps
module lldma_channel
    import lldma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int LEN_W  = 8,
    parameter int RIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              m_req_valid,
    input  logic              m_req_ready,
    output logic              m_req_we,
    output logic [AW-1:0]     m_req_addr,
    output logic [DW-1:0]     m_req_wdata,
    input  logic              m_rsp_valid,
    input  logic [DW-1:0]     m_rsp_data,
    input  logic              m_rsp_err,
    output logic              irq_blk,
    output logic              irq_tfr
);
    logic          start, sw_dst_we, sw_nxt_we, busy, blk_done, xfer_done, err;
    logic [AW-1:0] src_v, dst_v, nxt_v;
    logic [DW-1:0] ctl_v;

    lldma_regs #(.AW(AW), .DW(DW), .RIDX_W(RIDX_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .busy_i      (busy),
        .src_i       (src_v),
        .dst_i       (dst_v),
        .nxt_i       (nxt_v),
        .ctl_i       (ctl_v),
        .blk_i       (blk_done),
        .xfer_i      (xfer_done),
        .err_i       (err),
        .start_o     (start),
        .sw_dst_we_o (sw_dst_we),
        .sw_nxt_we_o (sw_nxt_we),
        .irq_blk_o   (irq_blk),
        .irq_tfr_o   (irq_tfr)
    );

    lldma_engine #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .sw_dst_we_i (sw_dst_we),
        .sw_nxt_we_i (sw_nxt_we),
        .sw_wdata_i  (AW'(reg_wdata)),
        .busy_o      (busy),
        .src_o       (src_v),
        .dst_o       (dst_v),
        .nxt_o       (nxt_v),
        .ctl_o       (ctl_v),
        .blk_done_o  (blk_done),
        .xfer_done_o (xfer_done),
        .err_o       (err),
        .m_req_valid (m_req_valid),
        .m_req_ready (m_req_ready),
        .m_req_we    (m_req_we),
        .m_req_addr  (m_req_addr),
        .m_req_wdata (m_req_wdata),
        .m_rsp_valid (m_rsp_valid),
        .m_rsp_data  (m_rsp_data),
        .m_rsp_err   (m_rsp_err)
    );
endmodule

// File: tb/tb_lldma_channel.sv
`timescale 1ns/1ps
module tb_lldma_channel;
    localparam int MEMW = 1024;
    localparam int SEQ  = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        m_req_valid, m_req_we;
    logic [31:0] m_req_addr, m_req_wdata;
    logic        m_req_ready = 1'b0;
    logic        m_rsp_valid = 1'b0;
    logic [31:0] m_rsp_data = '0;
    logic        m_rsp_err = 1'b0;
    logic        irq_blk, irq_tfr;

    always #10 clk = ~clk;

    lldma_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_we(m_req_we),
        .m_req_addr(m_req_addr), .m_req_wdata(m_req_wdata),
        .m_rsp_valid(m_rsp_valid), .m_rsp_data(m_rsp_data), .m_rsp_err(m_rsp_err),
        .irq_blk(irq_blk), .irq_tfr(irq_tfr)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem [0:MEMW-1];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    bit          stall_en = 1'b0;

    logic        g_we [0:SEQ-1];
    logic [31:0] g_addr [0:SEQ-1];
    logic [31:0] g_data [0:SEQ-1];
    int          g_n = 0;
    logic        e_we [0:SEQ-1];
    logic [31:0] e_addr [0:SEQ-1];
    logic [31:0] e_data [0:SEQ-1];
    int          e_n = 0;
    bit          e_stop = 1'b0;

    // Memory model: responds on the falling edge, one cycle after acceptance
    bit          pend = 1'b0;
    logic        p_we;
    logic [31:0] p_addr, p_wdata;
    int          ncyc = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            m_req_ready = 1'b0; m_rsp_valid = 1'b0; m_rsp_err = 1'b0; pend = 1'b0;
        end else begin
            m_rsp_valid = 1'b0;
            m_rsp_err   = 1'b0;
            if (pend) begin
                pend        = 1'b0;
                m_rsp_valid = 1'b1;
                m_rsp_err   = (p_addr == err_addr);
                if (p_we) begin
                    if (!m_rsp_err) mem[p_addr[11:2]] = p_wdata;
                end else m_rsp_data = mem[p_addr[11:2]];
            end
            ncyc++;
            m_req_ready = stall_en ? ((ncyc % 3) != 0) : 1'b1;
            if (m_req_valid && m_req_ready && !m_rsp_valid) begin
                pend = 1'b1; p_we = m_req_we; p_addr = m_req_addr; p_wdata = m_req_wdata;
                if (g_n < SEQ) begin
                    g_we[g_n] = m_req_we; g_addr[g_n] = m_req_addr; g_data[g_n] = m_req_wdata;
                end
                g_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    function automatic logic [31:0] pattern(input int i);
        return {8'h5A, 24'(i * 37 + 11)};
    endfunction

    function automatic logic [31:0] item_at(input int i);
        return 32'h100 + 32'(i * 32);
    endfunction

    function automatic logic [31:0] step(input logic [31:0] a, input int m);
        if (m == 0) return a + 32'd4;
        if (m == 1) return a - 32'd4;
        return a;
    endfunction

    task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d);
        if (e_stop) return;
        e_we[e_n] = we; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
        if (a == err_addr) e_stop = 1'b1;
    endtask

    int          lens [0:2];
    logic [31:0] ctls [0:2];
    logic [31:0] exp_dst;

    // Lays out the chain, computes the expected request sequence, runs it
    task automatic run_chain(input int n, input int sm, input int dm, input logic [2:0] mask,
                             input bit poke, input string tag);
        logic [31:0] sbase, dbase, s, d, r;
        int waited;
        for (int i = 0; i < MEMW; i++) mem[i] = pattern(i);
        sbase = (sm == 1) ? 32'h980 : 32'h800;
        dbase = (dm == 1) ? 32'hE00 : 32'hC00;
        for (int b = 0; b < n; b++) begin
            ctls[b] = 32'(lens[b]) | (32'(sm) << 8) | (32'(dm) << 10) | 32'h0010_0000;
            mem[item_at(b) >> 2]       = sbase + 32'(b * 256);
            mem[(item_at(b) >> 2) + 1] = 32'h0000_0FF0;
            mem[(item_at(b) >> 2) + 2] = (b == n - 1) ? 32'h0 : item_at(b + 1);
            mem[(item_at(b) >> 2) + 3] = ctls[b];
        end
        e_n = 0; e_stop = 1'b0;
        d = dbase;
        for (int b = 0; b < n; b++) begin
            for (int w = 0; w < 4; w++) push(1'b0, item_at(b) + 32'(w * 4), 32'h0);
            s = sbase + 32'(b * 256);
            for (int k = 0; k < lens[b]; k++) begin
                push(1'b0, s, 32'h0);
                push(1'b1, d, pattern(int'(s >> 2)));
                s = step(s, sm); d = step(d, dm);
            end
            push(1'b1, item_at(b) + 32'd12, ctls[b] | 32'h8000_0000);
        end
        exp_dst = d;
        g_n = 0;
        wr(4'd2, dbase);
        wr(4'd3, item_at(0));
        wr(4'd4, {29'd0, mask});
        wr(4'd1, 32'h1);
        if (poke) begin
            repeat (3) @(negedge clk);
            wr(4'd2, 32'h0000_0A00);   // R12: ignored while running
            wr(4'd3, 32'h0);           // R12: ignored while running
        end
        waited = 0;
        r = 32'h1;
        while (r[0] && waited < 4000) begin rd(4'd1, r); waited++; end
        chk(waited < 4000, {tag, " R8 channel returns to idle"}, 32'(waited), 32'd0);
        begin
            int bad = -1;
            for (int i = 0; i < e_n && i < SEQ; i++)
                if (bad < 0 && (i >= g_n || g_we[i] !== e_we[i] || g_addr[i] !== e_addr[i] ||
                    (e_we[i] && g_data[i] !== e_data[i]))) bad = i;
            chk(g_n == e_n, {tag, " R3 R5 request count"}, 32'(g_n), 32'(e_n));
            if (bad >= 0)
                chk(1'b0, {tag, " R3 R4 R5 request sequence"}, g_addr[bad], e_addr[bad]);
            else
                chk(1'b1, {tag, " R3 R4 R5 request sequence"}, 32'h0, 32'h0);
        end
    endtask

    logic [31:0] rv, rv2;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(4'd1, rv); chk(rv == 0, "R1 channel enable after reset", rv, 0);
        rd(4'd7, rv); chk(rv == 0, "R1 raw status after reset", rv, 0);
        rd(4'd8, rv); chk(rv == 0, "R1 masked status after reset", rv, 0);
        chk(!irq_blk && !irq_tfr, "R1 interrupts after reset", {30'd0, irq_blk, irq_tfr}, 0);
        chk(!m_req_valid, "R1 no request after reset", 32'(m_req_valid), 0);

        // R2: start refused without global enable, and on a zero write
        g_n = 0;
        wr(4'd3, item_at(0));
        wr(4'd1, 32'h1);
        repeat (20) @(negedge clk);
        chk(g_n == 0, "R2 no start without global enable", 32'(g_n), 0);
        rd(4'd1, rv); chk(rv == 0, "R2 channel stays off", rv, 0);
        wr(4'd0, 32'h1);
        wr(4'd1, 32'h0);
        repeat (20) @(negedge clk);
        chk(g_n == 0, "R2 writing 0 to enable does not start", 32'(g_n), 0);

        // Mode sweep, R3 R4 R5 R7 R8 R10 R11 R12
        for (int sm = 0; sm < 3; sm++) begin
            for (int dm = 0; dm < 3; dm++) begin
                stall_en = ((sm + dm) % 2) == 1;
                lens[0] = 3; lens[1] = 1; lens[2] = 2;
                run_chain(3, sm, dm, 3'b111, 1'b1, $sformatf("sweep s%0d d%0d", sm, dm));
                rd(4'd2, rv); chk(rv == exp_dst, "R4 R12 destination runs on", rv, exp_dst);
                rd(4'd7, rv); chk(rv == 32'h3, "R7 R8 raw status after chain", rv, 32'h3);
                chk(irq_tfr && irq_blk, "R11 both interrupts with full mask",
                    {30'd0, irq_blk, irq_tfr}, 32'h3);
                for (int b = 0; b < 3; b++) begin
                    rv2 = mem[(item_at(b) >> 2) + 3];
                    chk(rv2 == (ctls[b] | 32'h8000_0000), "R7 DONE written back", rv2,
                        ctls[b] | 32'h8000_0000);
                end
                wr(4'd9, 32'h1);
                rd(4'd7, rv); chk(rv == 32'h2, "R10 partial clear keeps block bit", rv, 32'h2);
                wr(4'd9, 32'h7);
                rd(4'd7, rv); chk(rv == 0, "R10 raw cleared", rv, 0);
                rd(4'd8, rv); chk(rv == 0, "R10 masked cleared", rv, 0);
            end
        end

        // R6: zero-length middle block
        stall_en = 1'b1;
        lens[0] = 2; lens[1] = 0; lens[2] = 1;
        run_chain(3, 0, 0, 3'b111, 1'b0, "R6 zero length");
        rd(4'd2, rv); chk(rv == exp_dst, "R6 destination after empty block", rv, exp_dst);
        rv2 = mem[(item_at(1) >> 2) + 3];
        chk(rv2 == (ctls[1] | 32'h8000_0000), "R6 empty block written back", rv2, ctls[1] | 32'h8000_0000);
        wr(4'd9, 32'h7);

        // R8: single item chain
        lens[0] = 4;
        run_chain(1, 0, 0, 3'b111, 1'b0, "R8 single item");
        rd(4'd7, rv); chk(rv == 32'h3, "R8 single item status", rv, 32'h3);
        wr(4'd9, 32'h7);

        // R11: partial mask
        lens[0] = 1; lens[1] = 1;
        run_chain(2, 0, 0, 3'b010, 1'b0, "R11 mask");
        rd(4'd8, rv); chk(rv == 32'h2, "R11 masked status", rv, 32'h2);
        chk(irq_blk && !irq_tfr, "R11 only block interrupt", {30'd0, irq_blk, irq_tfr}, 32'h2);
        rd(4'd7, rv); chk(rv == 32'h3, "R11 raw unaffected by mask", rv, 32'h3);
        wr(4'd9, 32'h7);

        // R9: error on a source read in block 1
        lens[0] = 2; lens[1] = 3; lens[2] = 1;
        err_addr = 32'h800 + 32'd256 + 32'd4;
        run_chain(3, 0, 0, 3'b111, 1'b0, "R9 source error");
        rd(4'd7, rv); chk(rv == 32'h6, "R9 error and block bits", rv, 32'h6);
        rd(4'd1, rv); chk(rv == 0, "R9 channel off after error", rv, 0);
        wr(4'd9, 32'h7);

        // R9: error on an item fetch
        err_addr = item_at(1) + 32'd8;
        run_chain(3, 0, 0, 3'b111, 1'b0, "R9 fetch error");
        rd(4'd7, rv); chk(rv == 32'h6, "R9 fetch error status", rv, 32'h6);
        err_addr = 32'hFFFF_FFFF;
        wr(4'd9, 32'h7);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule